// File: doc/BRIEF.md
# Checksummed Mirrored Record Writer

This block takes one ten-byte measurement record per transfer and stores it twice in a byte-wide memory. It accepts the record and its record index in a single valid/ready handshake and latches the bytes into a holding buffer. It then runs a 16-bit CRC over the ten data bytes, one byte per clock. When the checksum is complete, it writes a twelve-byte stored unit: the ten data bytes followed by the two checksum bytes.

The unit goes out through one write port. It is written first into the lower half of the memory and then, at the same offset, into the upper half. Because only one write path exists, the two copies are written one after the other. A later reader can compare the two copies and the checksums to recover from bit flips in either half.

The whole sequence has a fixed length, so the caller can budget for it against the arrival period of new records. A one-cycle completion pulse marks the end of the sequence, and a busy level covers its duration.

Top module: `mirror_rec_writer`

## Requirements
- R1: While reset is held and right after it is released, `rec_ready` is 1 and `busy`, `wr_en` and `done` are 0.
- R2: A record is taken when `rec_valid` and `rec_ready` are both 1 at a clock edge. From the next cycle on, `rec_ready` is 0 and `busy` is 1 until the cycle in which `done` is 1.
- R3: The checksum uses polynomial 0x1021 and initial value 0xFFFF. It shifts in data most significant bit first and applies no final XOR. It covers the ten data bytes in byte order, and data byte k is `rec_data[8k+7:8k]`.
- R4: Within a stored unit, offset k (0..9) holds data byte k, offset 10 holds checksum bits 15:8 and offset 11 holds checksum bits 7:0.
- R5: The primary copy is written in 12 consecutive strobes at addresses `rec_index*12 + k`, for k = 0..11 in increasing order.
- R6: Right after the last primary strobe, the mirror copy is written in 12 consecutive strobes with the same bytes, at the primary address plus half the memory size (2048 at default sizes).
- R7: Counting the accepting cycle as cycle 0, the write strobes occupy cycles 11 to 34 with no gap. `done` is 1 in cycle 35 only, and `rec_ready` is 1 again in cycle 35.
- R8: `rec_valid`, `rec_data` and `rec_index` presented while busy are ignored. The bytes, addresses and strobe count of the record in progress are unchanged, and no further write occurs after `done`.
- R9: A record presented in the cycle where `done` is 1 is accepted in that cycle, so records can follow each other with no idle cycle.
- R10: The highest index whose unit fits in one half (169 at default sizes) writes primary addresses 2028..2039 and mirror addresses 4076..4087.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rec_valid | input | 1 | A record is presented |
| rec_ready | output | 1 | Block can take a record |
| rec_data | input | 80 | Ten data bytes, byte k at bits 8k+7:8k |
| rec_index | input | 8 | Record slot number |
| wr_en | output | 1 | Memory write strobe |
| wr_addr | output | 12 | Memory byte address |
| wr_data | output | 8 | Memory write byte |
| busy | output | 1 | A record is being checksummed or written |
| done | output | 1 | One-cycle pulse after the last mirror byte |

## Verification
The hardest situation to reach is a new request arriving while a record is already in flight. This can happen in the middle of the sequence, or exactly in the completion cycle where it must be taken at once. The bench holds `rec_valid` high with different data and index for the whole busy window and checks that every one of the 24 bytes still belongs to the first record. It then chains records so that the next request sits on the bus in the `done` cycle. Using the top index and all-ones data pushes the addresses against the end of each half.

// File: rtl/mrw_pkg.sv
package mrw_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_CRC   = 2'd1,
        ST_WRITE = 2'd2
    } mrw_state_e;

    localparam logic [15:0] CRC_POLY = 16'h1021;
    localparam logic [15:0] CRC_SEED = 16'hFFFF;
    localparam int          CRC_BYTES = 2;
endpackage

// File: rtl/mrw_crc_byte.sv
// Advances a 16-bit checksum by one byte, most significant bit first.
module mrw_crc_byte
    import mrw_pkg::*;
(
    input  logic [15:0] crc_in,
    input  logic [7:0]  byte_in,
    output logic [15:0] crc_out
);
    logic [15:0] stage [0:8];

    assign stage[0] = crc_in;

    for (genvar i = 0; i < 8; i++) begin : g_bit
        logic fb;
        assign fb = stage[i][15] ^ byte_in[7-i];
        assign stage[i+1] = {stage[i][14:0], 1'b0} ^ (fb ? CRC_POLY : 16'h0000);
    end

    assign crc_out = stage[8];
endmodule

// File: rtl/mrw_byte_sel.sv
// Picks the byte at a given offset of the stored unit.
module mrw_byte_sel #(
    parameter int DATA_BYTES = 10,
    parameter int POS_W      = 4
) (
    input  logic [8*DATA_BYTES-1:0] hold,
    input  logic [15:0]             crc,
    input  logic [POS_W-1:0]        pos,
    output logic [7:0]              byte_out
);
    localparam int SH_W = POS_W + 3;

    logic [SH_W-1:0] shift;
    assign shift = {pos, 3'b000};

    always_comb begin
        if (int'(pos) < DATA_BYTES) begin
            byte_out = hold[shift +: 8];
        end else if (int'(pos) == DATA_BYTES) begin
            byte_out = crc[15:8];
        end else begin
            byte_out = crc[7:0];
        end
    end
endmodule

// File: rtl/mrw_addr_gen.sv
// Forms the memory address from slot number, copy select and offset.
module mrw_addr_gen #(
    parameter int ADDR_W    = 12,
    parameter int IDX_W     = 8,
    parameter int REC_BYTES = 12,
    parameter int POS_W     = 4
) (
    input  logic [IDX_W-1:0]  idx,
    input  logic              mirror,
    input  logic [POS_W-1:0]  pos,
    output logic [ADDR_W-1:0] addr
);
    localparam logic [ADDR_W-1:0] UNIT = ADDR_W'(REC_BYTES);

    logic [ADDR_W-1:0] base;
    logic [ADDR_W-1:0] half_off;

    assign base     = ADDR_W'(idx) * UNIT;
    assign half_off = {mirror, {(ADDR_W-1){1'b0}}};
    assign addr     = half_off + base + ADDR_W'(pos);
endmodule

// File: rtl/mirror_rec_writer.sv
module mirror_rec_writer
    import mrw_pkg::*;
#(
    parameter int DATA_BYTES = 10,
    parameter int ADDR_W     = 12,
    parameter int IDX_W      = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    rec_valid,
    output logic                    rec_ready,
    input  logic [8*DATA_BYTES-1:0] rec_data,
    input  logic [IDX_W-1:0]        rec_index,
    output logic                    wr_en,
    output logic [ADDR_W-1:0]       wr_addr,
    output logic [7:0]              wr_data,
    output logic                    busy,
    output logic                    done
);
    localparam int REC_BYTES = DATA_BYTES + CRC_BYTES;
    localparam int POS_W     = $clog2(REC_BYTES);
    localparam logic [POS_W-1:0] LAST_DATA = POS_W'(DATA_BYTES - 1);
    localparam logic [POS_W-1:0] LAST_POS  = POS_W'(REC_BYTES - 1);

    typedef struct packed {
        mrw_state_e              st;
        logic [POS_W-1:0]        pos;
        logic                    mirror;
        logic [15:0]             crc;
        logic [IDX_W-1:0]        idx;
        logic [8*DATA_BYTES-1:0] hold;
        logic                    done;
    } regs_t;

    regs_t r_q, r_d;

    logic [7:0]  cur_byte;
    logic [15:0] crc_next;

    mrw_byte_sel #(
        .DATA_BYTES (DATA_BYTES),
        .POS_W      (POS_W)
    ) u_sel (
        .hold     (r_q.hold),
        .crc      (r_q.crc),
        .pos      (r_q.pos),
        .byte_out (cur_byte)
    );

    mrw_crc_byte u_crc (
        .crc_in  (r_q.crc),
        .byte_in (cur_byte),
        .crc_out (crc_next)
    );

    mrw_addr_gen #(
        .ADDR_W    (ADDR_W),
        .IDX_W     (IDX_W),
        .REC_BYTES (REC_BYTES),
        .POS_W     (POS_W)
    ) u_addr (
        .idx    (r_q.idx),
        .mirror (r_q.mirror),
        .pos    (r_q.pos),
        .addr   (wr_addr)
    );

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        unique case (r_q.st)
            ST_IDLE: begin
                if (rec_valid) begin
                    r_d.st     = ST_CRC;
                    r_d.hold   = rec_data;
                    r_d.idx    = rec_index;
                    r_d.crc    = CRC_SEED;
                    r_d.pos    = '0;
                    r_d.mirror = 1'b0;
                end
            end
            ST_CRC: begin
                r_d.crc = crc_next;
                if (r_q.pos == LAST_DATA) begin
                    r_d.pos = '0;
                    r_d.st  = ST_WRITE;
                end else begin
                    r_d.pos = r_q.pos + POS_W'(1);
                end
            end
            ST_WRITE: begin
                if (r_q.pos == LAST_POS) begin
                    r_d.pos = '0;
                    if (r_q.mirror) begin
                        r_d.st     = ST_IDLE;
                        r_d.mirror = 1'b0;
                        r_d.done   = 1'b1;
                    end else begin
                        r_d.mirror = 1'b1;
                    end
                end else begin
                    r_d.pos = r_q.pos + POS_W'(1);
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.st     <= ST_IDLE;
            r_q.pos    <= '0;
            r_q.mirror <= 1'b0;
            r_q.crc    <= CRC_SEED;
            r_q.idx    <= '0;
            r_q.hold   <= '0;
            r_q.done   <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign rec_ready = (r_q.st == ST_IDLE);
    assign busy      = (r_q.st != ST_IDLE);
    assign wr_en     = (r_q.st == ST_WRITE);
    assign wr_data   = cur_byte;
    assign done      = r_q.done;

    // R2
    accept_then_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rec_valid && rec_ready |=> busy && !rec_ready);

    // R6
    first_primary_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && !$past(wr_en) |-> !wr_addr[ADDR_W-1]);

    // R5
    addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && $past(wr_en) && (wr_addr[ADDR_W-1] == $past(wr_addr[ADDR_W-1]))
        |-> wr_addr == $past(wr_addr) + ADDR_W'(1));

    // R7
    done_after_mirror_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(wr_en) && $past(wr_addr[ADDR_W-1]));

    // R7
    done_write_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({done, wr_en}));
endmodule

// File: tb/mirror_rec_writer_test.sv
module mirror_rec_writer_test;
    localparam int HALF = 2048;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rec_valid = 1'b0;
    logic        rec_ready;
    logic [79:0] rec_data = '0;
    logic [7:0]  rec_index = '0;
    logic        wr_en;
    logic [11:0] wr_addr;
    logic [7:0]  wr_data;
    logic        busy;
    logic        done;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    mirror_rec_writer uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .rec_valid (rec_valid),
        .rec_ready (rec_ready),
        .rec_data  (rec_data),
        .rec_index (rec_index),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .busy      (busy),
        .done      (done)
    );

    function automatic logic [15:0] ref_crc(input logic [79:0] d);
        logic [15:0] c;
        c = 16'hFFFF;
        for (int b = 0; b < 10; b++) begin
            for (int i = 7; i >= 0; i--) begin
                logic fb;
                fb = c[15] ^ d[b*8+i];
                c  = {c[14:0], 1'b0};
                if (fb) c = c ^ 16'h1021;
            end
        end
        return c;
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Drives one record from a negedge with the block idle; returns at the
    // negedge of cycle 35. With junk set, a different request is held during busy.
    task automatic send_record(input logic [7:0] idx, input logic [79:0] d,
                               input bit junk, input string req);
        logic [15:0] c;
        bit quiet;
        c = ref_crc(d);
        chk(rec_ready == 1'b1, "R2", "ready before accept", rec_ready, 1);
        rec_valid = 1'b1;
        rec_data  = d;
        rec_index = idx;
        @(negedge clk);
        if (junk) begin
            rec_data  = ~d;
            rec_index = idx ^ 8'h5A;
        end else begin
            rec_valid = 1'b0;
        end
        quiet = 1'b1;
        for (int cyc = 1; cyc <= 10; cyc++) begin
            if (wr_en || rec_ready || !busy || done) quiet = 1'b0;
            @(negedge clk);
        end
        chk(quiet, "R2", "checksum phase busy, no strobe", quiet, 1);
        for (int k = 0; k < 24; k++) begin
            int pos;
            int mir;
            logic [7:0]  eb;
            logic [11:0] ea;
            pos = k % 12;
            mir = k / 12;
            if (pos < 10) eb = d[pos*8 +: 8];
            else if (pos == 10) eb = c[15:8];
            else eb = c[7:0];
            ea = 12'(mir * HALF + int'(idx) * 12 + pos);
            chk(wr_en && !done && !rec_ready, "R7", "strobe window", {done, rec_ready, wr_en}, 1);
            chk(wr_addr == ea, mir ? "R6" : "R5", {req, " address"}, wr_addr, ea);
            chk(wr_data == eb, pos < 10 ? "R4" : "R3", {req, " byte"}, wr_data, eb);
            @(negedge clk);
        end
        chk(done && rec_ready && !wr_en && !busy, "R7", "done cycle 35",
            {done, rec_ready, wr_en, busy}, 4'b1100);
        rec_valid = 1'b0;
    endtask

    task automatic t_reset;
        chk(rec_ready && !busy && !wr_en && !done, "R1", "in reset",
            {rec_ready, busy, wr_en, done}, 4'b1000);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(rec_ready && !busy && !wr_en && !done, "R1", "after reset",
            {rec_ready, busy, wr_en, done}, 4'b1000);
    endtask

    task automatic t_basic;
        send_record(8'd0, 80'h0A09_0807_0605_0403_0201, 1'b0, "R5 basic");
        @(negedge clk);
        chk(!done && !busy, "R7", "done is one cycle", done, 0);
    endtask

    task automatic t_patterns;
        send_record(8'd3, '0, 1'b0, "R3 zeros");
        repeat (2) @(negedge clk);
        send_record(8'd77, 80'h31_32_33_34_35_36_37_38_39_30, 1'b0, "R3 ascii");
        repeat (2) @(negedge clk);
    endtask

    task automatic t_max_index;
        send_record(8'd169, {80{1'b1}}, 1'b0, "R10 top slot");
        repeat (2) @(negedge clk);
    endtask

    task automatic t_busy_ignored;
        bit idle_ok;
        send_record(8'd12, 80'hDEAD_BEEF_0123_4567_89AB, 1'b1, "R8 busy request");
        idle_ok = 1'b1;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            if (wr_en || busy) idle_ok = 1'b0;
        end
        chk(idle_ok, "R8", "no write after done", idle_ok, 1);
    endtask

    task automatic t_back_to_back;
        send_record(8'd5, 80'h1111_2222_3333_4444_5555, 1'b0, "R9 first");
        send_record(8'd6, 80'hAAAA_BBBB_CCCC_DDDD_EEEE, 1'b0, "R9 chained");
        send_record(8'd7, 80'h0F0F_F0F0_0F0F_F0F0_0F0F, 1'b0, "R9 chained");
        repeat (2) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        t_basic();
        t_patterns();
        t_max_index();
        t_busy_ignored();
        t_back_to_back();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule